// File: doc/BRIEF.md
# Two-Wire Serial Shifter with Readback Check

This block shifts one byte over a shared two-wire bus. The bus has a clock line and one open-drain data line. While the unit transmits, it samples the real level of the data line back into its shift register on every bit. When the byte is done, the register therefore holds what actually appeared on the bus, not what the unit meant to send. If another device pulled a bit low, the register shows that change.

An address register and an equality comparator turn that readback into a transmit check. Software loads the address register with the byte it is about to send and then writes the byte to the shift register, which starts the transfer. When the eighth bit completes, the comparator sets a match flag in the mode register. A 1 means the byte went out intact; a 0 means a collision or a line fault occurred. The unit can be clock master, using a programmable divider of the system clock, or clock slave, following an external clock through a two-flop synchroniser.

The host side is a simple register port with single-cycle writes and a combinational read. It has no back-pressure: a write to the shift register or to the mode register while a byte is in flight is dropped, and the host learns the transfer state from the byte-complete flag.

Top module: `tw_shift_unit`

## Requirements
- R1: After reset the shift register reads 0xFF, the address register reads 0x00, the mode register reads 0x00, `done` is 0, `sda_pull` is 0, `sck_o` is 1 and `sck_oe` is 0.
- R2: A write to the shift register while idle starts a transfer. In the same edge it clears `done` and the match flag.
- R3: Bits leave MSB first. The driven bit changes only after a falling clock edge (or on the starting write). The data output is open-drain: `sda_pull` is 1 exactly when the current bit is 0, and there is no high drive.
- R4: On each rising clock edge the register shifts left and takes the synchronised line level into bit 0. After a byte it holds the wired-AND of the sent byte and whatever other devices pulled low.
- R5: After eight rising clock edges the transfer ends, `done` goes to 1 and mode bit 2 reads 1. `done` is never 1 while a transfer is running.
- R6: At the end of each byte, the match flag (mode bit 1) becomes 1 if the final shift register equals the address register, and 0 otherwise. It holds until the next start.
- R7: Writes to the shift register or to the mode register during a transfer have no effect.
- R8: In master mode (mode bit 0 = 1, `sck_oe` = 1), each half period of `sck_o` lasts DIV+3 system cycles, where DIV is mode bits 7:4. `sck_o` rests high whenever no transfer runs.
- R9: In slave mode (mode bit 0 = 0, `sck_oe` = 0), the unit shifts on edges of `sck_i`, seen after a two-flop synchroniser. It completes a byte after eight external rising edges.
- R10: Writing 0xFF leaves the line released (`sda_pull` = 0). Writing 0x00 pulls it low (`sda_pull` = 1). Both hold from the write until the first falling clock edge.
- R11: `host_sel` selects 0 = shift register, 1 = address register, 2 = mode register, 3 = unused, which reads 0. The mode register fields are bit 0 master, bit 1 match, bit 2 done and bits 7:4 the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Single-cycle register write strobe |
| host_sel | input | 2 | Register select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | Bus clock level, used in slave mode |
| sck_o | output | 1 | Generated bus clock, idle high |
| sck_oe | output | 1 | Clock output enable (master mode) |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low |
| done | output | 1 | Byte-complete flag |

## Verification
The assertions assume that `rst_n` is applied before any host traffic and that `host_we` pulses for one cycle with a legal select. They also assume that the external clock half period in slave mode is longer than the synchroniser delay plus one cycle, so that the rise and fall events never coincide. The bench models the bus as a wired-AND of the unit and a second device and drives the external clock with eight-cycle half periods. It changes the second device's pull only right after a falling bus edge, so every sampled level has settled through the two synchroniser flops before the rising edge samples it.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_MODE = 2'd2,
    SEL_NONE = 2'd3
  } tws_sel_e;

  localparam int MODE_MASTER_BIT = 0;
  localparam int MODE_MATCH_BIT  = 1;
  localparam int MODE_DONE_BIT   = 2;
  localparam int MODE_DIV_LSB    = 4;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_clk.sv
module tws_clk #(
  parameter int DIV_W       = 4,
  parameter int MIN_HALF    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_master,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             busy,
  input  logic             sck_i,
  output logic             master,
  output logic [DIV_W-1:0] div,
  output logic             sck_o,
  output logic             fall_ev,
  output logic             rise_ev
);
  localparam int HALF_W = DIV_W + 2;

  logic [HALF_W-1:0] half_cnt;
  logic [HALF_W-1:0] half_lim;
  logic              run;
  logic              sck_q;
  logic              m_fall, m_rise;
  logic              sck_s, sck_prev;
  logic              s_fall, s_rise;

  // configuration is only taken while idle (gated by the top)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= 1'b0;
      div    <= '0;
    end else if (cfg_we) begin
      master <= cfg_master;
      div    <= cfg_div;
    end
  end

  assign half_lim = HALF_W'(div) + HALF_W'(MIN_HALF - 1);
  assign run      = busy & master;

  // master: divider toggles the bus clock, events are registered strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      sck_q    <= 1'b1;
      m_fall   <= 1'b0;
      m_rise   <= 1'b0;
    end else begin
      m_fall <= 1'b0;
      m_rise <= 1'b0;
      if (!run) begin
        half_cnt <= '0;
        sck_q    <= 1'b1;
      end else if (half_cnt == half_lim) begin
        half_cnt <= '0;
        sck_q    <= ~sck_q;
        m_fall   <= sck_q;
        m_rise   <= ~sck_q;
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  // slave: synchronised external clock, edge detect
  tws_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b1;
    else        sck_prev <= sck_s;
  end

  assign s_fall = sck_prev & ~sck_s;
  assign s_rise = ~sck_prev & sck_s;

  assign fall_ev = master ? m_fall : s_fall;
  assign rise_ev = master ? m_rise : s_rise;
  assign sck_o   = sck_q;

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_o); // R8
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ev && rise_ev)); // R3
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(master) && $stable(div)); // R7
endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              sda_i,
  output logic [DATA_W-1:0] sreg,
  output logic              out_bit,
  output logic              busy,
  output logic              done,
  output logic              fin,
  output logic [DATA_W-1:0] fin_val
);
  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bitcnt;
  logic             sda_s;

  tws_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
  );

  assign fin_val = {sreg[DATA_W-2:0], sda_s};
  assign fin     = busy && rise_ev && (bitcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '1;
      out_bit <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      bitcnt  <= '0;
    end else if (start) begin
      sreg    <= wdata;
      out_bit <= wdata[DATA_W-1];
      busy    <= 1'b1;
      done    <= 1'b0;
      bitcnt  <= '0;
    end else if (busy && fall_ev) begin
      out_bit <= sreg[DATA_W-1];
    end else if (busy && rise_ev) begin
      sreg <= fin_val;
      if (bitcnt == LAST) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        bitcnt <= '0;
      end else begin
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rise_ev) |=> $stable(sreg)); // R7
  AST_OUT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(busy && fall_ev)) |=> $stable(out_bit)); // R3
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_COUNT_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bitcnt == '0)); // R5
  AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done); // R5
endmodule

// File: rtl/tws_addr_cmp.sv
module tws_addr_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic              upd,
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] addr,
  output logic              match
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_we) addr <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    match <= 1'b0;
    else if (clr)  match <= 1'b0;
    else if (upd)  match <= (val == addr);
  end

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !match); // R2
  AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(match)); // R6
endmodule

// File: rtl/tw_shift_unit.sv
module tw_shift_unit #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 4,
  parameter int MIN_HALF    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sda_i,
  output logic              sda_pull,
  output logic              done
);
  import tws_pkg::*;

  tws_sel_e          sel;
  logic              busy, start, mode_we, addr_we;
  logic              master, match, out_bit, fin;
  logic              fall_ev, rise_ev;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] sreg, addr, fin_val;
  logic              unused_wbits;

  assign sel     = tws_sel_e'(host_sel);
  assign start   = host_we && (sel == SEL_DATA) && !busy;
  assign mode_we = host_we && (sel == SEL_MODE) && !busy;
  assign addr_we = host_we && (sel == SEL_ADDR);
  assign unused_wbits = ^host_wdata;

  tws_clk #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(mode_we),
    .cfg_master(host_wdata[MODE_MASTER_BIT]),
    .cfg_div(host_wdata[MODE_DIV_LSB +: DIV_W]),
    .busy(busy), .sck_i(sck_i),
    .master(master), .div(div), .sck_o(sck_o),
    .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  tws_shifter #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(start), .wdata(host_wdata),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .sda_i(sda_i),
    .sreg(sreg), .out_bit(out_bit), .busy(busy), .done(done),
    .fin(fin), .fin_val(fin_val)
  );

  tws_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .addr_we(addr_we), .wdata(host_wdata),
    .clr(start), .upd(fin), .val(fin_val),
    .addr(addr), .match(match)
  );

  assign sda_pull = ~out_bit;
  assign sck_oe   = master;

  always_comb begin
    host_rdata = '0;
    case (sel)
      SEL_DATA: host_rdata = sreg;
      SEL_ADDR: host_rdata = addr;
      SEL_MODE: begin
        host_rdata[MODE_MASTER_BIT]         = master;
        host_rdata[MODE_MATCH_BIT]          = match;
        host_rdata[MODE_DONE_BIT]           = done;
        host_rdata[MODE_DIV_LSB +: DIV_W]   = div;
      end
      default:  host_rdata = '0;
    endcase
  end

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && busy); // R2
  AST_CLOCK_HIGH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> sck_o || !master); // R8
endmodule

// File: tb/sim_tw_shift_unit.sv
module sim_tw_shift_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       sck_i = 1'b1;
  logic       sck_o, sck_oe, sda_pull, done;
  logic       ext_pull = 1'b0;
  logic       sda_i;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;

  assign sda_i = ~(sda_pull | ext_pull);

  always #5 clk = ~clk;

  tw_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sda_i(sda_i), .sda_pull(sda_pull), .done(done)
  );

  // {tx, other-device pulls, address, divider}
  localparam logic [31:0] VEC [0:5] = '{
    32'hA5_00_A5_00, 32'hA5_0F_A5_01, 32'h3C_00_C3_02,
    32'hFF_81_7E_00, 32'h00_00_00_05, 32'h96_FF_00_03
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    host_sel = sel; host_wdata = data; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [1:0] sel, output logic [7:0] data);
    @(negedge clk);
    host_sel = sel;
    #1 data = host_rdata;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic run_master(input logic [7:0] tx, input logic [7:0] mask, input bit poke,
                            output logic [7:0] obs, output int half);
    time tf, tr;
    hw(2'd0, tx);
    for (int k = 0; k < 8; k++) begin
      @(negedge sck_o);
      tf = $time;
      ext_pull = mask[7-k];
      @(posedge sck_o);
      tr = $time;
      #1 obs[7-k] = ~sda_pull;
      if (k == 0) half = int'((tr - tf) / 10);
      if (poke && k == 3) begin
        hw(2'd0, 8'h00);
        hw(2'd2, 8'h00);
      end
    end
    wait_done();
    ext_pull = 1'b0;
  endtask

  task automatic run_slave(input logic [7:0] mask);
    for (int k = 0; k < 8; k++) begin
      sck_i = 1'b0;
      ext_pull = mask[7-k];
      repeat (8) @(negedge clk);
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
    end
    ext_pull = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, obs, tx, mask, addr, expv;
    int half, dv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hr(2'd0, rd); chk("R1 shift reg", rd, 8'hFF);
    hr(2'd1, rd); chk("R1 addr reg", rd, 8'h00);
    hr(2'd2, rd); chk("R1 mode reg", rd, 8'h00);
    chk("R1 done", done, 1'b0);
    chk("R1 sda_pull", sda_pull, 1'b0);
    chk("R1 sck_o", sck_o, 1'b1);
    chk("R1 sck_oe", sck_oe, 1'b0);

    // vector table, master mode
    for (int v = 0; v < 6; v++) begin
      tx = VEC[v][31:24]; mask = VEC[v][23:16]; addr = VEC[v][15:8]; dv = int'(VEC[v][3:0]);
      expv = tx & ~mask;
      hw(2'd2, {VEC[v][3:0], 4'b0001});
      chk("R8 sck_oe in master", sck_oe, 1'b1);
      hw(2'd1, addr);
      hr(2'd1, rd); chk("R11 addr readback", rd, addr);
      run_master(tx, mask, 1'b0, obs, half);
      chk("R3 MSB-first driven bits", obs, tx);
      chk("R8 half period", half, dv + 3);
      chk("R5 done pin", done, 1'b1);
      hr(2'd0, rd); chk("R4 readback byte", rd, expv);
      hr(2'd2, rd);
      chk("R6 match flag", rd[1], expv == addr);
      chk("R5 done mode bit", rd[2], 1'b1);
      chk("R8 sck idle high", sck_o, 1'b1);
    end

    // R7 writes during a transfer are dropped
    hw(2'd2, 8'h41);
    hw(2'd1, 8'h5A);
    run_master(8'h5A, 8'h00, 1'b1, obs, half);
    hr(2'd0, rd); chk("R7 data write ignored", rd, 8'h5A);
    hr(2'd2, rd); chk("R7 mode write ignored", rd, 8'h47);

    // slave mode
    hw(2'd2, 8'h00);
    chk("R9 sck_oe in slave", sck_oe, 1'b0);
    hw(2'd0, 8'h00);
    chk("R10 zero byte pulls low", sda_pull, 1'b1);
    hr(2'd2, rd);
    chk("R2 match cleared on start", rd[1], 1'b0);
    chk("R2 done cleared on start", rd[2], 1'b0);
    run_slave(8'h00);
    chk("R9 slave done", done, 1'b1);
    hr(2'd0, rd); chk("R9 slave byte zero", rd, 8'h00);

    hw(2'd1, 8'hCC);
    hw(2'd0, 8'hFF);
    chk("R10 ones byte releases", sda_pull, 1'b0);
    run_slave(8'h33);
    hr(2'd0, rd); chk("R9 slave readback", rd, 8'hCC);
    hr(2'd2, rd); chk("R6 slave match", rd[1], 1'b1);
    chk("R9 sck_o rests high", sck_o, 1'b1);
    hr(2'd3, rd); chk("R11 unused select", rd, 8'h00);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule